// File: doc/BRIEF.md
# Two-Wire Bus Register-Write Slave

This block is the receive side of a two-wire serial control bus. It lets a bus master write 8-bit configuration registers inside the chip. Both bus lines enter the system clock domain through a short synchronizer. The block then finds the framing conditions in the synchronized samples, and a bit/byte engine shifts in each byte with the most significant bit first. The engine answers on the data line during the ninth clock pulse of each byte it accepts.

Every transaction has three bytes. The first carries the 7-bit device address and a direction flag. The second names the target register. The third carries the value to store. The store commits when the engine sees the clock rise during its acknowledge of the value byte. At that point the block emits a one-cycle write strobe with the index and data. The whole register bank is also presented as a flat vector, so the rest of the chip can read every setting in parallel. Reads, clock stretching, general call, 10-bit addressing and analog filtering are not part of this block.

Top module: `i2c_wreg_slave`

## Requirements
- R1: After synchronous reset every register reads 0, the data-line pull-down (`sda_drive_low`) is inactive and `wr_stb` is low.
- R2: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. Before the first START, and after a STOP, clocked bus traffic is ignored: no byte is acknowledged and no register changes.
- R3: The first byte after a START is taken MSB first. The block acknowledges it only when its upper seven bits equal 7'b0011010 (0x1A) and its bit 0 (the direction flag) is 0, meaning write. A byte of 0x34 is therefore acknowledged, while 0x35 and any other address are not.
- R4: After an acknowledged address byte, the block acknowledges the register-index byte and the data byte.
- R5: The block turns on the pull-down only while SCL is low. It keeps the pull-down on through the whole high phase of the ninth pulse and turns it off after that pulse falls.
- R6: The register named by the index byte holds its old value until the SCL rise of the acknowledge pulse that follows the data byte. It holds the new value during that high phase. At that point `wr_stb` is high for exactly one clock, with `wr_idx` and `wr_data` carrying the index and value.
- R7: A write whose index is NREG or above (default 16) is still acknowledged. It raises no strobe and changes no register.
- R8: The block does not acknowledge a byte sent after the data byte and before a STOP, and such a byte changes no register.
- R9: A repeated START discards any partly received transfer. The next byte is treated as a new address byte.
- R10: A STOP during a transfer returns the block to idle, and the unfinished write is discarded.
- R11: After an address byte that is not acknowledged, the block acknowledges nothing and writes nothing until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls the data line low (acknowledge); 0 releases it |
| wr_stb | output | 1 | One-cycle pulse when a register write commits |
| wr_idx | output | 8 | Register index of the committed write |
| wr_data | output | 8 | Value of the committed write |
| reg_bank | output | NREG*8 | All registers, register k at bits [8k+7:8k] |

## Verification
Some properties are checked on every cycle. The pull-down may only switch on while the clock is low and must stay on for the whole high phase. A strobe must fall inside an acknowledge, last one cycle and carry an in-range index. The bank must stay untouched on cycles without a write and take exactly the strobed value after one. Other behaviours show only across a whole bus transaction, so the bench's scenarios must cover them. These are: which address and direction bytes are acknowledged, the exact pulse on which the value lands, and the discarding of transfers cut short by a repeated START or a STOP. The same applies to ignoring extra bytes, out-of-range indices and traffic outside a START.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BITS = 2'd1,
    ST_ACK  = 2'd2,
    ST_SKIP = 2'd3
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
// Synchronizes both bus lines into clk and derives edges and framing events.
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end
  endgenerate

  // previous synchronized sample, used for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = ~scl_q & scl_s;
  assign scl_fall  = scl_q & ~scl_s;
  assign start_det = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;

  // R2
  framing_needs_high_clk_chk: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |-> $past(scl_s));
endmodule

// File: rtl/tw_rx_fsm.sv
// Bit/byte engine: shifts bytes in, decides acknowledges, issues the commit.
module tw_rx_fsm
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0011010,
  parameter int         NREG     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int         CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);
  localparam logic [BYTE_W:0]  NREG_LIM = (BYTE_W+1)'(NREG);

  tw_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [1:0]        byte_cnt;   // 0 addr, 1 index, 2 data, 3 surplus
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] idx_q;
  logic              ack_pend;

  function automatic logic byte_ok(input logic [BYTE_W-1:0] b, input logic [1:0] pos);
    case (pos)
      2'd0:    byte_ok = (b[BYTE_W-1:1] == DEV_ADDR) && !b[0];
      2'd1,
      2'd2:    byte_ok = 1'b1;
      default: byte_ok = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
      idx_q    <= '0;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state    <= ST_BITS;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        ack_pend <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_BITS: begin
            if (scl_rise && bit_cnt != FULL) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT)
                ack_pend <= byte_ok({shreg[BYTE_W-2:0], sda_s}, byte_cnt);
            end else if (scl_fall && bit_cnt == FULL) begin
              if (ack_pend) begin
                state  <= ST_ACK;
                sda_oe <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_rise) begin
              if (byte_cnt == 2'd1)
                idx_q <= shreg;
              if (byte_cnt == 2'd2 && ({1'b0, idx_q} < NREG_LIM)) begin
                wr_stb  <= 1'b1;
                wr_idx  <= idx_q;
                wr_data <= shreg;
              end
            end else if (scl_fall) begin
              sda_oe   <= 1'b0;
              state    <= ST_BITS;
              bit_cnt  <= '0;
              if (byte_cnt != 2'd3)
                byte_cnt <= byte_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  ack_drive_on_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
  // R5
  ack_held_while_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && scl_s && !start_det && !stop_det) |=> sda_oe);
  // R6
  commit_inside_ack_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (sda_oe && scl_s));
  // R6
  commit_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  // R7
  commit_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ({1'b0, wr_idx} < NREG_LIM));
  // R3
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= FULL);
endmodule

// File: rtl/tw_regbank.sv
// Register storage; every entry is visible at once, so flops rather than RAM.
module tw_regbank
  import tw_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [BYTE_W-1:0]      wr_idx,
  input  logic [BYTE_W-1:0]      wr_data,
  output logic [NREG*BYTE_W-1:0] regs_flat
);
  localparam logic [BYTE_W:0] NREG_LIM = (BYTE_W+1)'(NREG);

  logic [BYTE_W-1:0] mem [NREG];
  logic              wr_hit;

  assign wr_hit = wr_en && ({1'b0, wr_idx} < NREG_LIM);

  generate
    for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst)
          mem[gi] <= '0;
        else if (wr_hit && wr_idx == BYTE_W'(gi))
          mem[gi] <= wr_data;
      end
      assign regs_flat[gi*BYTE_W +: BYTE_W] = mem[gi];
    end
  endgenerate

  // R7
  bank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(regs_flat));
  // R6
  bank_takes_value_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/i2c_wreg_slave.sv
module i2c_wreg_slave
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0011010,
  parameter int         NREG        = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_drive_low,
  output logic                   wr_stb,
  output logic [7:0]             wr_idx,
  output logic [7:0]             wr_data,
  output logic [NREG*8-1:0]      reg_bank
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tw_rx_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_drive_low),
    .wr_stb    (wr_stb),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  tw_regbank #(.NREG(NREG)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_stb),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .regs_flat (reg_bank)
  );
endmodule

// File: tb/tb_i2c_wreg_slave.sv
`timescale 1ns/1ps
module tb_i2c_wreg_slave;
  localparam int         NREG = 16;
  localparam logic [6:0] ADDR = 7'b0011010;
  localparam int         Q    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_bus;
  logic sda_drive_low, wr_stb;
  logic [7:0] wr_idx, wr_data;
  logic [NREG*8-1:0] reg_bank;

  assign sda_bus = m_sda & ~sda_drive_low;

  i2c_wreg_slave #(.NREG(NREG)) dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_drive_low(sda_drive_low), .wr_stb(wr_stb),
    .wr_idx(wr_idx), .wr_data(wr_data), .reg_bank(reg_bank)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int stb_cnt = 0;
  logic [7:0] last_idx = '0, last_data = '0;
  logic [7:0] exp_regs [NREG];
  logic [NREG*8-1:0] pre_bank, mid_bank;
  logic released_ok;

  always @(posedge clk) begin
    if (!rst && wr_stb) begin
      stb_cnt   <= stb_cnt + 1;
      last_idx  <= wr_idx;
      last_data <= wr_data;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < NREG; i++)
      chk(req, int'(reg_bank[i*8 +: 8]), int'(exp_regs[i]));
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wq(Q);
    pre_bank = reg_bank;
    m_scl = 1'b1; wq(Q);
    acked    = ~sda_bus;
    mid_bank = reg_bank;
    wq(Q);
    m_scl = 1'b0; wq(Q);
    released_ok = ~sda_drive_low;
  endtask

  function automatic logic addr_ok(input logic [7:0] b);
    return (b[7:1] == ADDR) && !b[0];
  endfunction

  task automatic full_write(input logic [7:0] a, input logic [7:0] idx,
                            input logic [7:0] d, input string req);
    logic k0, k1, k2, ex;
    int s0;
    s0 = stb_cnt;
    ex = addr_ok(a);
    bus_start;
    send_byte(a, k0);
    send_byte(idx, k1);
    send_byte(d, k2);
    bus_stop;
    if (ex && idx < NREG) exp_regs[idx] = d;
    chk({req, " R3 addr ack"}, int'(k0), int'(ex));
    chk({req, " R4 idx ack"}, int'(k1), int'(ex));
    chk({req, " R4 data ack"}, int'(k2), int'(ex));
    chk({req, " R7 strobe count"}, stb_cnt - s0, (ex && idx < NREG) ? 1 : 0);
    chk_bank({req, " R6 bank"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic k;
    int s0;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < NREG; i++) exp_regs[i] = '0;
    wq(10);
    rst = 1'b0;
    wq(4);
    // R1 reset state
    chk_bank("R1 reset bank");
    chk("R1 pull-down idle", int'(sda_drive_low), 0);
    chk("R1 strobe idle", int'(wr_stb), 0);

    // R2 traffic before any START is ignored
    send_byte({ADDR, 1'b0}, k);
    chk("R2 no ack without START", int'(k), 0);

    // R6 commit timing on a basic write
    s0 = stb_cnt;
    full_write({ADDR, 1'b0}, 8'd3, 8'hA5, "basic");
    chk("R6 old value before ack rise", int'(pre_bank[3*8 +: 8]), 0);
    chk("R6 new value in ack high", int'(mid_bank[3*8 +: 8]), 8'hA5);
    chk("R6 strobe index", int'(last_idx), 3);
    chk("R6 strobe data", int'(last_data), 8'hA5);
    chk("R5 released after ack", int'(released_ok), 1);
    chk("R6 one strobe", stb_cnt - s0, 1);

    // R3 wrong address and read direction; R11 rest ignored
    full_write({7'b0011011, 1'b0}, 8'd4, 8'h5A, "R11 wrong addr");
    full_write({ADDR, 1'b1}, 8'd4, 8'h5A, "R3 read dir");

    // R7 out-of-range index acked but ignored
    full_write({ADDR, 1'b0}, 8'd20, 8'hEE, "R7 range");
    full_write({ADDR, 1'b0}, 8'd15, 8'h0F, "R7 top index");

    // R8 surplus byte
    bus_start;
    send_byte({ADDR, 1'b0}, k);
    send_byte(8'd5, k);
    send_byte(8'h11, k);
    exp_regs[5] = 8'h11;
    send_byte(8'h22, k);
    chk("R8 surplus nack", int'(k), 0);
    bus_stop;
    chk_bank("R8 surplus no write");

    // R9 repeated START mid data byte
    bus_start;
    send_byte({ADDR, 1'b0}, k);
    send_byte(8'd7, k);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    m_scl = 1'b0;
    bus_start;
    send_byte({ADDR, 1'b0}, k);
    chk("R9 new address acked", int'(k), 1);
    send_byte(8'd8, k);
    send_byte(8'h3C, k);
    bus_stop;
    exp_regs[8] = 8'h3C;
    chk_bank("R9 partial discarded");

    // R10 STOP after index, then R2 traffic after STOP ignored
    s0 = stb_cnt;
    bus_start;
    send_byte({ADDR, 1'b0}, k);
    send_byte(8'd9, k);
    bus_stop;
    m_scl = 1'b0; wq(Q);
    send_byte(8'h77, k);
    chk("R2 no ack after STOP", int'(k), 0);
    m_scl = 1'b1; wq(Q);
    chk("R10 no strobe", stb_cnt - s0, 0);
    chk_bank("R10 nothing written");

    // random mix
    for (int t = 0; t < 60; t++) begin
      logic [7:0] a, idx, d;
      a   = ($urandom % 4 != 0) ? {ADDR, 1'b0} : 8'($urandom);
      if ($urandom % 6 == 0) a[0] = 1'b1;
      idx = 8'($urandom % (NREG + 4));
      d   = 8'($urandom);
      full_write(a, idx, d, "random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule